// File: doc/BRIEF.md
# Stereo Sense-Data Serial Transmitter

This block streams sensed output voltage and output current out of the chip as a two-channel serial word stream. It runs directly on the serial bit clock. An external word-select (WS) input marks the channel boundaries: low for the left half-frame and high for the right half-frame. The left half-frame carries the voltage sample and the right half-frame carries the current sample. Optionally, an 8-bit supply-rail reading follows the voltage word in the left half-frame.

A two-bit format code selects how data lines up with WS:
- Standard framing: the MSB comes one bit clock after the WS change.
- Left-justified framing: the MSB comes with the WS change.
- Reduced-rate framing: 32 bit clocks per frame, with standard framing and 16-bit halves.

All three sample inputs are captured together at the start of every left half-frame. A consumer therefore always receives a coherent voltage/current/supply set per frame.

Timing convention: `sdata` is a register clocked by `clk`. The rising edge at which `clk` first samples WS at a new level is bit position 0 of the new half-frame. The `sdata` value that leaves that edge carries position 0. Position p leaves the p-th following edge.

Top module: `sense_i2s_tx`

## Requirements
- R1: While `rst` is high, `sdata` is 0. After reset, `sdata` stays 0 until WS first changes level.
- R2: The left half-frame (WS low) carries the 16-bit voltage word and the right half-frame (WS high) carries the 16-bit current word. Each word is sent MSB first.
- R3: Every bit position after the last payload bit of a half-frame is driven 0 until WS changes again.
- R4: With `fmtMode` = 0 (standard framing), position 0 is a delay bit of value 0 in both halves, and the word MSB is at position 1.
- R5: With `fmtMode` = 1 (left-justified framing), the word MSB is at position 0 of each half-frame.
- R6: When `appendSupply` is 1 and `fmtMode` is 0 or 1, the 8-bit supply word is sent MSB first directly after the voltage LSB. It appears in the left half-frame only.
- R7: With `fmtMode` = 2 or 3 (reduced rate, 16 bit clocks per half-frame), standard framing is used: delay bit at position 0, MSB at position 1.
- R8: In reduced-rate mode, the delay bit at position 0 carries the LSB of the word sent in the previous half-frame. That is the voltage LSB at a right start and the previous frame's current LSB at a left start.
- R9: In reduced-rate mode `appendSupply` has no effect, and the left half-frame carries only the 16-bit voltage word.
- R10: All three samples are captured at the bit position 0 of each left half-frame. Input changes at any other position do not alter the words sent until the next left half-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ws | input | 1 | Word select from the frame master: 0 left/voltage, 1 right/current |
| fmtMode | input | 2 | 0 standard, 1 left-justified, 2 or 3 reduced-rate standard |
| appendSupply | input | 1 | Append the supply word after the voltage word (normal rate only) |
| voltSample | input | 16 | Voltage sample, two's complement |
| currSample | input | 16 | Current sample, two's complement |
| supplySample | input | 8 | Supply-rail reading |
| sdata | output | 1 | Serial data, registered |

## Verification
The delay bit is the sharpest corner. A design that drops the delay would shift every word one place toward the MSB. In reduced-rate mode, a design that forgot the carried LSB would lose the last bit of each word into a zero.

The appended supply byte is checked in both framings and in reduced-rate mode. A wrong gate there would either truncate the left word or leak supply bits into a 16-bit half.

Samples are changed in the middle of the left half-frame. A transmitter that sampled continuously instead of capturing at the left start would then send a torn voltage/current pair. The idle window after reset catches an output that starts shifting before the first WS edge.

// File: rtl/sense_i2s_pkg.sv
package sense_i2s_pkg;

  // Framing codes carried on fmtMode.
  typedef enum logic [1:0] {
    FMT_STD     = 2'd0,
    FMT_LJ      = 2'd1,
    FMT_LOW     = 2'd2,
    FMT_LOW_ALT = 2'd3
  } fmtMode_e;

  // Strobes from the control section to the datapath.
  typedef struct packed {
    logic leftStart;  // position 0 of a left half-frame
    logic chanRight;  // current half-frame is the right one
    logic active;     // framing established since reset
  } serStrobe_t;

endpackage

// File: rtl/sense_i2s_ctrl.sv
module sense_i2s_ctrl
  import sense_i2s_pkg::*;
#(
  parameter int POS_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ws,
  output serStrobe_t       strb,
  output logic [POS_W-1:0] pos
);

  localparam logic [POS_W-1:0] POS_LAST = '1;

  logic             primed;
  logic             wsPrev;
  logic             synced;
  logic [POS_W-1:0] posReg;
  logic             wsEdge;

  // A WS change is only trusted once wsPrev holds a post-reset value.
  always_comb begin
    wsEdge         = primed && (ws != wsPrev);
    pos            = wsEdge ? '0 : posReg;
    strb.leftStart = wsEdge && !ws;
    strb.chanRight = ws;
    strb.active    = synced || wsEdge;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed <= 1'b0;
      wsPrev <= 1'b0;
      synced <= 1'b0;
      posReg <= POS_LAST;
    end else begin
      primed <= 1'b1;
      wsPrev <= ws;
      if (wsEdge) synced <= 1'b1;
      // Saturate so an overlong half-frame keeps emitting padding.
      posReg <= (pos == POS_LAST) ? pos : pos + 1'b1;
    end
  end

endmodule

// File: rtl/sense_i2s_dp.sv
module sense_i2s_dp
  import sense_i2s_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SUPPLY_W = 8,
  parameter int POS_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  serStrobe_t          strb,
  input  logic [POS_W-1:0]    pos,
  input  logic [1:0]          fmtMode,
  input  logic                appendSupply,
  input  logic [SAMPLE_W-1:0] voltSample,
  input  logic [SAMPLE_W-1:0] currSample,
  input  logic [SUPPLY_W-1:0] supplySample,
  output logic                sdata
);

  localparam int STREAM_W = 1 << POS_W;
  localparam int LONG_W   = SAMPLE_W + SUPPLY_W;
  localparam int PAD_L    = STREAM_W - LONG_W;
  localparam int PAD_R    = STREAM_W - SAMPLE_W;

  logic [SAMPLE_W-1:0] vHold, iHold;
  logic [SUPPLY_W-1:0] sHold;
  logic [SAMPLE_W-1:0] vUse, iUse;
  logic [SUPPLY_W-1:0] sUse;
  logic                isLj, lowRate, appendOn;
  logic [STREAM_W-1:0] leftMsb, rightMsb, leftRev, rightRev;
  logic [POS_W-1:0]    idx;
  logic                carryBit, sdataNext;

  always_comb begin
    isLj     = (fmtMode_e'(fmtMode) == FMT_LJ);
    lowRate  = fmtMode[1];
    appendOn = appendSupply && !lowRate;
    // At a left start the fresh inputs are used directly; the holds load on the same edge.
    vUse     = strb.leftStart ? voltSample   : vHold;
    iUse     = strb.leftStart ? currSample   : iHold;
    sUse     = strb.leftStart ? supplySample : sHold;
    leftMsb  = STREAM_W'({vUse, appendOn ? sUse : {SUPPLY_W{1'b0}}}) << PAD_L;
    rightMsb = STREAM_W'(iUse) << PAD_R;
  end

  // Reverse the MSB-first streams so bit position indexes them directly.
  for (genvar j = 0; j < STREAM_W; j++) begin : g_rev
    assign leftRev[j]  = leftMsb[STREAM_W-1-j];
    assign rightRev[j] = rightMsb[STREAM_W-1-j];
  end

  always_comb begin
    idx = isLj ? pos : pos - 1'b1;
    // Reduced rate: a full 16-bit word overflows into the next half's delay slot.
    carryBit = lowRate && (strb.chanRight ? vHold[0] : iHold[0]);
    if (!strb.active)
      sdataNext = 1'b0;
    else if (!isLj && pos == '0)
      sdataNext = carryBit;
    else
      sdataNext = strb.chanRight ? rightRev[idx] : leftRev[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vHold <= '0;
      iHold <= '0;
      sHold <= '0;
      sdata <= 1'b0;
    end else begin
      if (strb.leftStart) begin
        vHold <= voltSample;
        iHold <= currSample;
        sHold <= supplySample;
      end
      sdata <= sdataNext;
    end
  end

endmodule

// File: rtl/sense_i2s_tx.sv
module sense_i2s_tx
  import sense_i2s_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int SUPPLY_W  = 8,
  parameter int HALF_BITS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ws,
  input  logic [1:0]          fmtMode,
  input  logic                appendSupply,
  input  logic [SAMPLE_W-1:0] voltSample,
  input  logic [SAMPLE_W-1:0] currSample,
  input  logic [SUPPLY_W-1:0] supplySample,
  output logic                sdata
);

  localparam int POS_W = $clog2(HALF_BITS);

  serStrobe_t       strb;
  logic [POS_W-1:0] pos;

  sense_i2s_ctrl #(.POS_W(POS_W)) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .ws   (ws),
    .strb (strb),
    .pos  (pos)
  );

  sense_i2s_dp #(
    .SAMPLE_W (SAMPLE_W),
    .SUPPLY_W (SUPPLY_W),
    .POS_W    (POS_W)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .pos          (pos),
    .fmtMode      (fmtMode),
    .appendSupply (appendSupply),
    .voltSample   (voltSample),
    .currSample   (currSample),
    .supplySample (supplySample),
    .sdata        (sdata)
  );

endmodule

// File: rtl/sense_i2s_tx_chk.sv
module sense_i2s_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic       ws,
  input logic [1:0] fmtMode,
  input logic       voltMsb,
  input logic       sdata
);

  logic [2:0] age;
  logic       primedQ, wsQ, seenQ;
  logic [5:0] cnt;
  logic       edgeQ;

  assign edgeQ = primedQ && (ws != wsQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      age     <= '0;
      primedQ <= 1'b0;
      wsQ     <= 1'b0;
      seenQ   <= 1'b0;
      cnt     <= '1;
    end else begin
      if (age != 3'd7) age <= age + 3'd1;
      primedQ <= 1'b1;
      wsQ     <= ws;
      if (edgeQ) seenQ <= 1'b1;
      cnt <= edgeQ ? 6'd0 : ((cnt == 6'h3f) ? cnt : cnt + 6'd1);
    end
  end

  // R1: quiet until the first WS change
  p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
    !seenQ |-> !sdata);

  // R3: padding after the longest normal-rate word is low
  p_tail_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (seenQ && !fmtMode[1] && cnt >= 6'd25) |-> !sdata);

  // R4: standard framing puts a zero delay bit at position 0
  p_std_delay_r4: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd3 && fmtMode == 2'd0 && ($past(ws) != $past(ws, 2))) |-> !sdata);

  // R4: voltage MSB follows one bit clock after the left start
  p_std_msb_r4: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd4 && fmtMode == 2'd0 && !$past(ws, 2) && $past(ws, 3) && !$past(ws))
      |-> (sdata == $past(voltMsb, 2)));

  // R5: left-justified MSB sits at the left start
  p_lj_msb_r5: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd3 && fmtMode == 2'd1 && !$past(ws) && $past(ws, 2))
      |-> (sdata == $past(voltMsb)));

endmodule

bind sense_i2s_tx sense_i2s_tx_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .ws      (ws),
  .fmtMode (fmtMode),
  .voltMsb (voltSample[SAMPLE_W-1]),
  .sdata   (sdata)
);

// File: tb/sense_i2s_tx_tb.sv
module sense_i2s_tx_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ws = 1'b1;
  logic [1:0]  fmtMode = 2'd0;
  logic        appendSupply = 1'b0;
  logic [15:0] voltSample = '0;
  logic [15:0] currSample = '0;
  logic [7:0]  supplySample = '0;
  logic        sdata;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;
  logic [15:0] prevI = '0;

  always #2 clk = ~clk;

  sense_i2s_tx u_dut (
    .clk          (clk),
    .rst          (rst),
    .ws           (ws),
    .fmtMode      (fmtMode),
    .appendSupply (appendSupply),
    .voltSample   (voltSample),
    .currSample   (currSample),
    .supplySample (supplySample),
    .sdata        (sdata)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected half-frame stream (first bit in the MSB of the low L bits).
  function automatic logic [31:0] expHalf(input logic isRight, input logic [1:0] md,
                                          input logic app, input logic [15:0] v,
                                          input logic [15:0] i, input logic [7:0] s,
                                          input logic carry, input int L);
    logic [31:0] word, st;
    logic low;
    low  = md[1];
    word = isRight ? {i, 16'h0} : {v, (app && !low) ? s : 8'h00, 8'h00};
    st   = (md == 2'd1) ? word : {carry, word[31:1]};
    return st >> (32 - L);
  endfunction

  task automatic runFrame(input logic [1:0] md, input logic app,
                          input logic [15:0] v, input logic [15:0] i, input logic [7:0] s,
                          input logic [15:0] vLate, input logic [15:0] iLate,
                          input logic [7:0] sLate, input int L,
                          input string tagL, input string tagR);
    logic [31:0] act;
    act = '0;
    for (int b = 0; b < L; b++) begin
      @(negedge clk);
      ws = 1'b0;
      if (b == 0) begin
        fmtMode = md; appendSupply = app;
        voltSample = v; currSample = i; supplySample = s;
      end
      if (b == 5) begin
        voltSample = vLate; currSample = iLate; supplySample = sLate;
      end
      @(posedge clk); #1;
      act = {act[30:0], sdata};
    end
    check(act, expHalf(1'b0, md, app, v, i, s, md[1] ? prevI[0] : 1'b0, L), tagL);
    act = '0;
    for (int b = 0; b < L; b++) begin
      @(negedge clk);
      ws = 1'b1;
      @(posedge clk); #1;
      act = {act[30:0], sdata};
    end
    check(act, expHalf(1'b1, md, app, v, i, s, md[1] ? v[0] : 1'b0, L), tagR);
    prevI = i;
  endtask

  task automatic t_reset;
    logic [31:0] act;
    act = '0;
    repeat (3) begin
      @(posedge clk); #1;
      act = {act[30:0], sdata};
    end
    check(act, 32'h0, "R1 during reset");
    @(negedge clk); rst = 1'b0;
    act = '0;
    repeat (5) begin
      @(posedge clk); #1;
      act = {act[30:0], sdata};
    end
    check(act, 32'h0, "R1 idle before first WS change");
  endtask

  task automatic t_standard;
    runFrame(2'd0, 1'b0, 16'hA5C3, 16'h5A3C, 8'hFF, 16'hA5C3, 16'h5A3C, 8'hFF, 32,
             "R2 R4 left std", "R2 R3 right std");
    runFrame(2'd0, 1'b0, 16'h8001, 16'hFFFF, 8'h00, 16'h8001, 16'hFFFF, 8'h00, 32,
             "R3 R4 left std", "R3 R4 right std");
  endtask

  task automatic t_leftjust;
    runFrame(2'd1, 1'b0, 16'hC001, 16'h7FFE, 8'h3C, 16'hC001, 16'h7FFE, 8'h3C, 32,
             "R5 left lj", "R5 right lj");
    runFrame(2'd1, 1'b0, 16'hFFFF, 16'h8000, 8'h00, 16'hFFFF, 16'h8000, 8'h00, 32,
             "R5 R3 left lj", "R5 R3 right lj");
  endtask

  task automatic t_append;
    runFrame(2'd0, 1'b1, 16'h1234, 16'hBEEF, 8'hA7, 16'h1234, 16'hBEEF, 8'hA7, 32,
             "R6 left std append", "R6 right std append");
    runFrame(2'd1, 1'b1, 16'hF00F, 16'h0FF0, 8'h81, 16'hF00F, 16'h0FF0, 8'h81, 32,
             "R6 left lj append", "R6 right lj append");
  endtask

  task automatic t_lowrate;
    runFrame(2'd2, 1'b0, 16'h8003, 16'h4001, 8'h00, 16'h8003, 16'h4001, 8'h00, 16,
             "R7 left low", "R8 right low carry");
    runFrame(2'd2, 1'b0, 16'h7FFE, 16'hFFFE, 8'h00, 16'h7FFE, 16'hFFFE, 8'h00, 16,
             "R8 left low carry", "R7 right low");
    runFrame(2'd3, 1'b0, 16'hAAAB, 16'h5555, 8'h00, 16'hAAAB, 16'h5555, 8'h00, 16,
             "R7 left code3", "R8 right code3");
  endtask

  task automatic t_lowAppend;
    runFrame(2'd2, 1'b1, 16'h9C31, 16'h63CE, 8'hFF, 16'h9C31, 16'h63CE, 8'hFF, 16,
             "R9 left low append ignored", "R9 right low append ignored");
  endtask

  task automatic t_latch;
    runFrame(2'd0, 1'b1, 16'h1357, 16'h2468, 8'h5A, 16'hECA8, 16'hDB97, 8'hA5, 32,
             "R10 left mid-frame change", "R10 right mid-frame change");
    runFrame(2'd1, 1'b1, 16'hECA8, 16'hDB97, 8'hA5, 16'h0000, 16'h0000, 8'h00, 32,
             "R10 left next frame", "R10 right next frame");
  endtask

  initial begin
    t_reset();
    t_standard();
    t_leftjust();
    t_append();
    t_lowrate();
    t_lowAppend();
    t_latch();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule